// File: doc/BRIEF.md
# Anti-Tamper Configuration Supervisor

This block is a supervisory state machine that takes a protected target device from power-up into monitored user operation and then watches it for tamper evidence. After power-on reset completes, it asks an external JTAG sequencer to unlock the target's test port, then to program the decryption key. It re-locks the port by removing the target's analog supply for a fixed number of cycles, and finally asks an external bitstream loader to configure the target. Each external step reports back through the target's status pin or through the loader's done and error inputs.

Once the target reports that initialization is done, the supervisor enters monitoring. Here it counts configuration-memory CRC error events and runs a watchdog on a heartbeat clock that the target drives. A CRC event or a lost heartbeat clears the target through its active-low configuration-clear pin. An operator push-button then starts a reload. When a fourth CRC event arrives after three have been counted, or when the loader reports an error, the supervisor enters a lockout state that only a reset leaves. Status LEDs show monitoring, heartbeat loss, CRC hit and lockout.

Top module: `tamper_supervisor`

## Requirements
- R1: During reset, and while `por_done` stays low afterwards, all request outputs are 0, `rail_en` and `cfg_clear_n` are 1, and all LEDs are off.
- R2: With `por_done` high, `jtag_unlock_req` is raised. Each of the unlock and key-programming steps advances only on a rising edge of the synchronized `tgt_status`. A status that stays high does not advance the key step, which keeps `key_prog_req` raised.
- R3: When the key step completes, `rail_en` goes to 0 for exactly RAIL_OFF_CYCLES consecutive cycles and then returns to 1. `loader_req` rises in the same cycle that `rail_en` returns.
- R4: While `loader_req` is high, `init_done` high moves the block into monitoring, which lights `led_run` alone. Before `init_done`, `led_run` stays off.
- R5: During monitoring, a rising edge of the synchronized `tgt_crc_err` with fewer than CRC_LIMIT (3) counted events moves to the CRC-hit state. That state lights `led_crc` and drives `cfg_clear_n` low. Only rising edges seen during monitoring are counted. Edges in other states are ignored.
- R6: A CRC rising edge during monitoring with CRC_LIMIT events already counted moves to lockout. The count is cleared by `rst_n` and by `restart_req`.
- R7: In the CRC-hit and heartbeat-lost states, `cfg_clear_n` stays low until `pgm_btn`. The button moves to reload, where `loader_req` is 1 and `cfg_clear_n` is 1. `init_done` then returns the block to monitoring.
- R8: In lockout, `led_run` and `led_osc` are equal. Both are on at entry, and both toggle every BLINK_HALF cycles. `pgm_btn`, `init_done` and CRC edges have no effect there. Only `rst_n` or `restart_req` leaves lockout.
- R9: During monitoring, heartbeat edges that arrive at intervals shorter than HB_TIMEOUT keep the block in monitoring. If no edge arrives for HB_TIMEOUT cycles, the block moves to the heartbeat-lost state, which lights `led_osc` alone and drives `cfg_clear_n` low.
- R10: `cfg_error` high while `loader_req` is high moves to lockout.
- R11: `restart_req` returns the block from any state to the reset state. If `por_done` is high, `jtag_unlock_req` follows on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_req | input | 1 | Synchronous restart; returns to the reset state from anywhere |
| por_done | input | 1 | Power rails of the target are stable |
| tgt_status | input | 1 | Target status pin (asynchronous), high when a JTAG step completes |
| tgt_crc_err | input | 1 | Target CRC error pin (asynchronous) |
| tgt_heartbeat | input | 1 | Clock from the target's internal oscillator (asynchronous) |
| init_done | input | 1 | Target configuration finished |
| cfg_error | input | 1 | Loader reports a configuration failure |
| pgm_btn | input | 1 | Operator reload button, synchronous level |
| jtag_unlock_req | output | 1 | Request to the JTAG sequencer: unlock the port |
| key_prog_req | output | 1 | Request to the JTAG sequencer: program the key |
| rail_en | output | 1 | Enable for the target's analog supply regulator |
| loader_req | output | 1 | Request to the bitstream loader: configure the target |
| cfg_clear_n | output | 1 | Active-low configuration clear to the target |
| led_run | output | 1 | Monitoring LED; blinks in lockout |
| led_osc | output | 1 | Heartbeat-lost LED; blinks in lockout |
| led_crc | output | 1 | CRC-hit LED |

## Verification
The bench counts every cycle that the analog rail is held off. A cycler that is off by one shows a gap of RAIL_OFF_CYCLES plus or minus one. It also checks that a status line left high does not skip the key step, which a level-sensitive design would do. CRC pulses are issued while the block is already in the CRC-hit state, and the bench then expects lockout on exactly the fourth event seen during monitoring. A counter that also counted outside monitoring, or that compared the count after incrementing it, would lock out one event early. The bench varies the heartbeat period at random and then stops the heartbeat. It requires the loss to be flagged only after HB_TIMEOUT quiet cycles and within a small synchronizer margin. It also measures the blink half-period in lockout, and presses the reload button there to confirm that lockout is not left without a reset.

// File: rtl/ts_pkg.sv
package ts_pkg;
   typedef enum logic [3:0] {
      ST_BOOT     = 4'd0,
      ST_UNLOCK   = 4'd1,
      ST_KEYLOAD  = 4'd2,
      ST_RELOCK   = 4'd3,
      ST_WATCH    = 4'd4,
      ST_CRC_HIT  = 4'd5,
      ST_CLK_LOST = 4'd6,
      ST_RELOAD   = 4'd7,
      ST_LOCKOUT  = 4'd8
   } sup_state_e;
endpackage

// File: rtl/ts_sync.sv
module ts_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ts_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ts_hb_watchdog.sv
module ts_hb_watchdog #(
   parameter int TIMEOUT = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic hb_sync,
   output logic timeout
);
   localparam int CW = $clog2(TIMEOUT + 1);

   if (TIMEOUT < 4) begin : g_bad_timeout
      $error("ts_hb_watchdog: TIMEOUT must be at least 4");
   end

   logic          hb_prev;
   logic [CW-1:0] remain;
   logic          hb_edge;

   assign hb_edge = hb_sync ^ hb_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hb_prev <= 1'b0;
         remain  <= CW'(TIMEOUT);
      end else begin
         hb_prev <= hb_sync;
         if (!arm || hb_edge)  remain <= CW'(TIMEOUT);
         else if (remain != '0) remain <= remain - 1'b1;
      end
   end

   assign timeout = arm && (remain == '0);
endmodule

// File: rtl/ts_evt_counter.sv
module ts_evt_counter #(
   parameter int LIMIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_limit
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("ts_evt_counter: LIMIT must be at least 1");
   end

   logic [CW-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          count <= '0;
      else if (clr)                        count <= '0;
      else if (inc && count != CW'(LIMIT)) count <= count + 1'b1;
   end

   assign at_limit = (count == CW'(LIMIT));
endmodule

// File: rtl/ts_rail_cycler.sv
module ts_rail_cycler #(
   parameter int OFF_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic rail_en,
   output logic restored
);
   localparam int CW = $clog2(OFF_CYCLES + 1);

   if (OFF_CYCLES < 1) begin : g_bad_off
      $error("ts_rail_cycler: OFF_CYCLES must be at least 1");
   end

   logic [CW-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         held <= '0;
      else if (!go)                       held <= '0;
      else if (held != CW'(OFF_CYCLES))   held <= held + 1'b1;
   end

   assign rail_en  = !(go && held != CW'(OFF_CYCLES));
   assign restored = go && held == CW'(OFF_CYCLES);
endmodule

// File: rtl/tamper_supervisor.sv
module tamper_supervisor #(
   parameter int RAIL_OFF_CYCLES = 16,
   parameter int HB_TIMEOUT      = 32,
   parameter int CRC_LIMIT       = 3,
   parameter int BLINK_HALF      = 8,
   parameter int SYNC_STAGES     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_req,
   input  logic por_done,
   input  logic tgt_status,
   input  logic tgt_crc_err,
   input  logic tgt_heartbeat,
   input  logic init_done,
   input  logic cfg_error,
   input  logic pgm_btn,
   output logic jtag_unlock_req,
   output logic key_prog_req,
   output logic rail_en,
   output logic loader_req,
   output logic cfg_clear_n,
   output logic led_run,
   output logic led_osc,
   output logic led_crc
);
   import ts_pkg::*;

   localparam int BW = $clog2(BLINK_HALF + 1);

   if (BLINK_HALF < 2) begin : g_bad_blink
      $error("tamper_supervisor: BLINK_HALF must be at least 2");
   end

   sup_state_e state_q, state_d;

   logic status_s, crc_s, hb_s;
   logic status_prev, crc_prev;
   logic status_rise, crc_rise;
   logic hb_timeout, crc_at_limit;
   logic rail_restored;
   logic [BW-1:0] blink_cnt;
   logic blink_on;

   ts_sync #(.STAGES(SYNC_STAGES)) u_sync_status (
      .clk(clk), .rst_n(rst_n), .d(tgt_status), .q(status_s));
   ts_sync #(.STAGES(SYNC_STAGES)) u_sync_crc (
      .clk(clk), .rst_n(rst_n), .d(tgt_crc_err), .q(crc_s));
   ts_sync #(.STAGES(SYNC_STAGES)) u_sync_hb (
      .clk(clk), .rst_n(rst_n), .d(tgt_heartbeat), .q(hb_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_prev <= 1'b0;
         crc_prev    <= 1'b0;
      end else begin
         status_prev <= status_s;
         crc_prev    <= crc_s;
      end
   end

   assign status_rise = status_s && !status_prev;
   assign crc_rise    = crc_s && !crc_prev;

   ts_hb_watchdog #(.TIMEOUT(HB_TIMEOUT)) u_wdog (
      .clk(clk), .rst_n(rst_n), .arm(state_q == ST_WATCH),
      .hb_sync(hb_s), .timeout(hb_timeout));

   ts_evt_counter #(.LIMIT(CRC_LIMIT)) u_crc_cnt (
      .clk(clk), .rst_n(rst_n), .clr(restart_req),
      .inc(crc_rise && state_q == ST_WATCH), .at_limit(crc_at_limit));

   ts_rail_cycler #(.OFF_CYCLES(RAIL_OFF_CYCLES)) u_rail (
      .clk(clk), .rst_n(rst_n), .go(state_q == ST_RELOCK),
      .rail_en(rail_en), .restored(rail_restored));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_BOOT:     if (por_done) state_d = ST_UNLOCK;
         ST_UNLOCK:   if (status_rise) state_d = ST_KEYLOAD;
         ST_KEYLOAD:  if (status_rise) state_d = ST_RELOCK;
         ST_RELOCK: begin
            if (cfg_error && rail_restored)      state_d = ST_LOCKOUT;
            else if (rail_restored && init_done) state_d = ST_WATCH;
         end
         ST_WATCH: begin
            if (crc_rise)        state_d = crc_at_limit ? ST_LOCKOUT : ST_CRC_HIT;
            else if (hb_timeout) state_d = ST_CLK_LOST;
         end
         ST_CRC_HIT, ST_CLK_LOST: if (pgm_btn) state_d = ST_RELOAD;
         ST_RELOAD: begin
            if (cfg_error)      state_d = ST_LOCKOUT;
            else if (init_done) state_d = ST_WATCH;
         end
         ST_LOCKOUT:  state_d = ST_LOCKOUT;
         default:     state_d = ST_BOOT;
      endcase
      if (restart_req) state_d = ST_BOOT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_BOOT;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blink_cnt <= '0;
         blink_on  <= 1'b1;
      end else if (state_q != ST_LOCKOUT) begin
         blink_cnt <= '0;
         blink_on  <= 1'b1;
      end else if (blink_cnt == BW'(BLINK_HALF - 1)) begin
         blink_cnt <= '0;
         blink_on  <= !blink_on;
      end else begin
         blink_cnt <= blink_cnt + 1'b1;
      end
   end

   assign jtag_unlock_req = (state_q == ST_UNLOCK);
   assign key_prog_req    = (state_q == ST_KEYLOAD);
   assign loader_req      = (state_q == ST_RELOAD) || rail_restored;
   assign cfg_clear_n     = !(state_q == ST_CRC_HIT || state_q == ST_CLK_LOST);
   assign led_run         = (state_q == ST_WATCH)    || (state_q == ST_LOCKOUT && blink_on);
   assign led_osc         = (state_q == ST_CLK_LOST) || (state_q == ST_LOCKOUT && blink_on);
   assign led_crc         = (state_q == ST_CRC_HIT);
endmodule

// File: rtl/ts_checker.sv
module ts_checker (
   input logic             clk,
   input logic             rst_n,
   input logic             restart_req,
   input logic             init_done,
   input logic             jtag_unlock_req,
   input logic             key_prog_req,
   input logic             rail_en,
   input logic             loader_req,
   input logic             cfg_clear_n,
   input logic             led_run,
   input logic             led_osc,
   input logic             led_crc,
   input ts_pkg::sup_state_e state_q
);
   import ts_pkg::*;

   p_one_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({jtag_unlock_req, key_prog_req, loader_req, led_crc}));

   p_rail_after_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rail_en) |-> $past(key_prog_req));

   p_watch_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(led_run) && !led_osc) |-> ($past(loader_req) && $past(init_done)));

   p_crc_from_watch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(led_crc) |-> ($past(led_run) && !cfg_clear_n));

   p_osc_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (led_osc && !led_run) |-> !cfg_clear_n);

   p_lockout_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOCKOUT && !restart_req) |=> (state_q == ST_LOCKOUT));

   p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |=> (state_q == ST_BOOT));
endmodule

bind tamper_supervisor ts_checker u_chk (
   .clk(clk), .rst_n(rst_n), .restart_req(restart_req), .init_done(init_done),
   .jtag_unlock_req(jtag_unlock_req), .key_prog_req(key_prog_req),
   .rail_en(rail_en), .loader_req(loader_req), .cfg_clear_n(cfg_clear_n),
   .led_run(led_run), .led_osc(led_osc), .led_crc(led_crc), .state_q(state_q));

// File: tb/tamper_supervisor_tb.sv
module tamper_supervisor_tb_top;
   localparam int RAIL_OFF = 16;
   localparam int HB_TO    = 32;
   localparam int LIMIT    = 3;
   localparam int BLINK    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic restart_req = 1'b0, por_done = 1'b0, tgt_status = 1'b0, tgt_crc_err = 1'b0;
   logic tgt_heartbeat = 1'b0, init_done = 1'b0, cfg_error = 1'b0, pgm_btn = 1'b0;
   logic jtag_unlock_req, key_prog_req, rail_en, loader_req, cfg_clear_n;
   logic led_run, led_osc, led_crc;

   int n_tests = 0, n_fail = 0;
   int cyc = 0;
   int hb_half = 6, hb_cnt = 0, last_toggle = 0;
   bit hb_run = 1'b0;
   int crc_model = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (hb_run) begin
         if (hb_cnt >= hb_half - 1) begin
            tgt_heartbeat <= ~tgt_heartbeat;
            hb_cnt <= 0;
            last_toggle <= cyc;
         end else hb_cnt <= hb_cnt + 1;
      end
   end

   tamper_supervisor #(.RAIL_OFF_CYCLES(RAIL_OFF), .HB_TIMEOUT(HB_TO),
      .CRC_LIMIT(LIMIT), .BLINK_HALF(BLINK), .SYNC_STAGES(2)) dut_i (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic bit crc_goes_lockout(input int counted);
      return counted >= LIMIT;
   endfunction

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // walk from the reset state into monitoring
   task automatic boot();
      int n;
      n = 0;
      while (!jtag_unlock_req && n < 20) begin tick(1); n++; end
      chk(jtag_unlock_req, "R2 unlock request", jtag_unlock_req, 1);
      tick(6);
      chk(jtag_unlock_req && !key_prog_req, "R2 waits for status", key_prog_req, 0);
      tgt_status = 1'b1;
      n = 0;
      while (!key_prog_req && n < 10) begin tick(1); n++; end
      chk(key_prog_req, "R2 key request after status rise", key_prog_req, 1);
      tick(12);
      chk(key_prog_req && rail_en, "R2 held status does not advance", key_prog_req, 1);
      tgt_status = 1'b0;
      tick(3);
      tgt_status = 1'b1;
      n = 0;
      while (rail_en && n < 10) begin tick(1); n++; end
      n = 0;
      while (!rail_en && n < RAIL_OFF + 10) begin tick(1); n++; end
      chk(n == RAIL_OFF, "R3 rail off duration", n, RAIL_OFF);
      chk(loader_req, "R3 loader request on rail return", loader_req, 1);
      tgt_status = 1'b0;
      tick(5);
      chk(!led_run && loader_req, "R4 no monitoring before init_done", led_run, 0);
      init_done = 1'b1;
      n = 0;
      while (!led_run && n < 4) begin tick(1); n++; end
      init_done = 1'b0;
      chk(led_run && !led_osc && !led_crc, "R4 monitoring entered", led_run, 1);
   endtask

   task automatic crc_pulse();
      tgt_crc_err = 1'b1; tick(4); tgt_crc_err = 1'b0;
   endtask

   // returns 1 if lockout reached
   task automatic crc_event(output bit locked);
      int n;
      bit exp_lock;
      exp_lock = crc_goes_lockout(crc_model);
      crc_pulse();
      n = 0;
      while (!led_crc && !(led_run && led_osc) && n < 6) begin tick(1); n++; end
      locked = led_run && led_osc;
      if (exp_lock) begin
         chk(locked && !led_crc, "R6 limit reached goes to lockout", locked, 1);
      end else begin
         chk(led_crc && !cfg_clear_n && !led_run, "R5 CRC hit clears target", led_crc, 1);
         if (crc_model < LIMIT) crc_model++;
      end
   endtask

   task automatic reload();
      int n;
      tick(3);
      chk(!cfg_clear_n, "R7 clear held until button", cfg_clear_n, 0);
      pgm_btn = 1'b1; tick(1); pgm_btn = 1'b0;
      chk(loader_req && cfg_clear_n, "R7 reload requests loader", loader_req, 1);
      init_done = 1'b1;
      n = 0;
      while (!led_run && n < 4) begin tick(1); n++; end
      init_done = 1'b0;
      chk(led_run && !led_osc, "R7 back to monitoring", led_run, 1);
   endtask

   task automatic lockout_checks();
      int n;
      int gap;
      chk(led_run == led_osc, "R8 LEDs equal", led_run, led_osc);
      n = 0;
      while (led_run && n < 3 * BLINK) begin tick(1); n++; end
      gap = 0;
      while (!led_run && gap < 3 * BLINK) begin
         chk(led_run == led_osc && !loader_req, "R8 equal while off", led_osc, led_run);
         tick(1); gap++;
      end
      chk(gap == BLINK, "R8 blink half period", gap, BLINK);
      pgm_btn = 1'b1; init_done = 1'b1; tick(2); pgm_btn = 1'b0; init_done = 1'b0;
      crc_pulse();
      for (int i = 0; i < 2 * BLINK; i++) begin
         chk(!loader_req && !led_crc && cfg_clear_n && led_run == led_osc,
             "R8 lockout ignores inputs", loader_req, 0);
         tick(1);
      end
   endtask

   task automatic restart();
      restart_req = 1'b1; tick(1); restart_req = 1'b0;
      chk(!led_run && !led_osc && !loader_req, "R11 restart to reset", led_run, 0);
      tick(1);
      chk(jtag_unlock_req, "R11 unlock follows restart", jtag_unlock_req, 1);
      crc_model = 0;
   endtask

   task automatic hb_loss();
      int n;
      int quiet;
      hb_run = 1'b0;
      n = 0;
      while (!led_osc && n < HB_TO + 40) begin tick(1); n++; end
      quiet = cyc - last_toggle;
      chk(led_osc && !led_run && !cfg_clear_n, "R9 heartbeat loss flagged", led_osc, 1);
      chk(quiet >= HB_TO && quiet <= HB_TO + 8, "R9 timeout window", quiet, HB_TO);
      hb_run = 1'b1;
   endtask

   initial begin
      #(200000 * 10);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      bit lk;
      void'($urandom(32'd4711));
      tick(3);
      chk(!jtag_unlock_req && !key_prog_req && !loader_req && rail_en && cfg_clear_n
          && !led_run && !led_osc && !led_crc, "R1 reset outputs", rail_en, 1);
      rst_n = 1'b1;
      tick(10);
      chk(!jtag_unlock_req && rail_en && !led_run, "R1 waits for por_done", jtag_unlock_req, 0);
      hb_run = 1'b1;
      por_done = 1'b1;
      boot();

      // R9 random heartbeat periods keep monitoring
      for (int i = 0; i < 4; i++) begin
         hb_half = 2 + int'($urandom % 10);
         for (int k = 0; k < 80; k++) begin
            if (!led_run) chk(1'b0, "R9 heartbeat keeps monitoring", led_run, 1);
            tick(1);
         end
         n_tests++;
      end

      // first CRC event, then extra pulse inside CRC hit (must not count)
      crc_event(lk);
      crc_pulse();
      tick(4);
      chk(led_crc, "R5 pulse outside monitoring ignored", led_crc, 1);
      reload();
      crc_event(lk); reload();
      crc_event(lk); reload();
      crc_event(lk);
      chk(lk, "R6 fourth monitored event locks out", lk, 1);
      lockout_checks();
      restart();
      boot();

      // count cleared by restart
      crc_event(lk);
      chk(!lk, "R6 count cleared by restart", lk, 0);
      reload();

      // heartbeat loss then loader error
      hb_loss();
      tick(3);
      pgm_btn = 1'b1; tick(1); pgm_btn = 1'b0;
      cfg_error = 1'b1; tick(2); cfg_error = 1'b0;
      chk(led_run && led_osc, "R10 loader error locks out", led_osc, 1);
      restart();
      boot();

      // random mix
      for (int i = 0; i < 8; i++) begin
         hb_half = 2 + int'($urandom % 10);
         tick(40 + int'($urandom % 60));
         chk(led_run && !led_osc, "R9 stays monitoring", led_run, 1);
         if ($urandom % 2 == 0) begin
            crc_event(lk);
            if (lk) begin restart(); boot(); end
            else reload();
         end else begin
            hb_loss();
            reload();
         end
      end

      // R10 during first configuration after rail return
      restart();
      begin
         int n;
         tgt_status = 1'b1; tick(4); tgt_status = 1'b0; tick(3);
         tgt_status = 1'b1; tick(4); tgt_status = 1'b0;
         n = 0;
         while (!loader_req && n < RAIL_OFF + 20) begin tick(1); n++; end
         cfg_error = 1'b1; tick(2); cfg_error = 1'b0;
         chk(led_run && led_osc, "R10 error during first load", led_run, 1);
      end
      rst_n = 1'b0; tick(2); rst_n = 1'b1;
      chk(!led_run && !led_osc && rail_en, "R8 reset leaves lockout", led_run, 0);
      tick(5);
      finish_run();
   end
endmodule